// File: doc/BRIEF.md
# One-wire bus slot sequencer

This block turns a single slot request into the exact low/release waveform on an open-drain one-wire line. A requester presents a two-bit request kind and a data bit together with a one-cycle start strobe. The block then times the slot: it drives the line low for a fixed number of microseconds, releases it, optionally samples the line at a fixed offset after release, and waits out the rest of the slot. The slot ends with a one-cycle done pulse. For read-type slots the sampled level is on `bitOut`. For a bus reset, `bitOut` holds the presence result.

A prescaler derived from the clock frequency produces the microsecond time base. An integer scale factor, captured when a slot starts, stretches every delay of that slot. The line appears at the ports as a pull-low enable plus a raw input, which passes through a two-stage synchronizer before it is sampled. Byte assembly, address search, CRC and strong pull-up control belong to the requester.

Top module: `ow_slot_gen`

## Requirements
- R1: After reset, `driveLow`, `busy`, `done` and `bitOut` are all 0.
- R2: Request kind 1 with `reqBit`=1 is a write-1 slot. The line is pulled low for 6 µs·k, then released for 64 µs·k, then done pulses. Here k is the latched scale.
- R3: Request kind 1 with `reqBit`=0 is a write-0 slot. The line is pulled low for 60 µs·k, then released for 10 µs·k.
- R4: Request kind 3 is a read slot. The line is pulled low for 6 µs·k and released. The line is sampled 9 µs·k after release, and done comes 55 µs·k after the sample. `bitOut` then holds the sampled level.
- R5: Request kind 0 is a bus reset. The line is pulled low for 500 µs·k and released, then sampled 70 µs·k after release. A further 430 µs·k recovery follows before done. `bitOut` is the sampled level: 0 means a device answered, 1 means none.
- R6: Request kind 2 is a touch. With `reqBit`=1 it runs a read slot and returns the sample. With `reqBit`=0 it runs a write-0 slot.
- R7: Every delay is multiplied by `delayScale`, which is latched at slot start. A value of 0 acts as 1, and a change during a slot has no effect on that slot.
- R8: One microsecond equals `CLK_HZ`/1,000,000 clocks. Every interval is an exact multiple of that. `driveLow` rises in the first cycle after the accepting clock edge.
- R9: The line input passes through two flip-flops. A sample reflects the line level two clock edges before the sampling edge.
- R10: `busy` is high from the accepting edge until the edge that raises `done`. `done` is a one-cycle pulse. A start while busy is ignored.
- R11: Write-0 slots, write-1 slots and touch-with-0 slots return `bitOut`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle slot request strobe |
| reqKind | input | 2 | 0 reset, 1 write, 2 touch, 3 read |
| reqBit | input | 1 | Data bit for write and touch requests |
| delayScale | input | COEF_W | Delay multiplier, 0 treated as 1 |
| lineIn | input | 1 | Raw level seen on the bus line |
| driveLow | output | 1 | Pull-low enable for the open-drain driver |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle end-of-slot pulse |
| bitOut | output | 1 | Sampled bit or presence result |

## Verification
The accepting edge is the clock edge at which `start` is seen while idle. `driveLow` follows one cycle later and stays up for exactly low·k·CLKS_PER_US cycles. The sample lands low+offset scaled cycles after the accepting edge, and `done` rises with `busy` falling exactly the full slot length after it. The bench keeps a behavioural model that advances on the same rising edge. It compares all four outputs at every falling edge, so an interval off by one cycle shows at once. Per-slot counters check measured low time, busy length and the returned bit against the requirement figures. Two probes move the line one cycle either side of the synchronizer window.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

  typedef enum logic [1:0] {
    REQ_RESET = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_TOUCH = 2'd2,
    REQ_READ  = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    SLOT_WR0 = 2'd0,
    SLOT_WR1 = 2'd1,
    SLOT_RD  = 2'd2,
    SLOT_RST = 2'd3
  } slotType_e;

  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_GAP  = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    phase_e    phase;
    slotType_e slotType;
    logic      capture;
    logic      latchCfg;
  } ctrlStrobe_t;

  localparam int unsigned MAX_BASE_US = 500;

  // phase lengths in microseconds before scaling
  function automatic int unsigned baseMicros(slotType_e t, phase_e p);
    int unsigned r;
    r = 1;
    case (t)
      SLOT_WR1, SLOT_RD: begin
        case (p)
          PH_LOW:  r = 6;
          PH_GAP:  r = 9;
          default: r = 55;
        endcase
      end
      SLOT_WR0: begin
        case (p)
          PH_LOW:  r = 60;
          PH_GAP:  r = 5;
          default: r = 5;
        endcase
      end
      default: begin
        case (p)
          PH_LOW:  r = 500;
          PH_GAP:  r = 70;
          default: r = 430;
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic slotType_e decodeReq(reqKind_e k, logic b);
    slotType_e t;
    case (k)
      REQ_RESET: t = SLOT_RST;
      REQ_WRITE: t = b ? SLOT_WR1 : SLOT_WR0;
      REQ_TOUCH: t = b ? SLOT_RD : SLOT_WR0;
      default:   t = SLOT_RD;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/ow_slot_tick.sv
module ow_slot_tick #(
  parameter int unsigned CLKS_PER_US = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CNT_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_US - 1);

  logic [CNT_W-1:0] cntQ;

  assign tick = (cntQ == LAST);

  always_ff @(posedge clk) begin
    if (!rstN || clr || tick) cntQ <= '0;
    else                      cntQ <= cntQ + 1'b1;
  end

  // R8
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (cntQ == '0));

endmodule

// File: rtl/ow_slot_datapath.sv
module ow_slot_datapath
  import ow_slot_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned COEF_W      = 4,
  parameter int unsigned SYNC_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [COEF_W-1:0] delayScale,
  input  logic              lineIn,
  output logic              expire,
  output logic              bitOut
);
  localparam int unsigned MAX_COEF = (1 << COEF_W) - 1;
  localparam int unsigned TIMER_W  = $clog2(MAX_BASE_US * MAX_COEF + 1);

  logic                  tick;
  logic [COEF_W-1:0]     coefQ;
  logic [COEF_W-1:0]     scaleIn;
  logic [COEF_W-1:0]     coefEff;
  logic [TIMER_W-1:0]    timerQ;
  logic [TIMER_W-1:0]    loadVal;
  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  lineSync;
  logic                  sampleQ;

  ow_slot_tick #(.CLKS_PER_US(CLKS_PER_US)) i_tick (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobe.load),
    .tick (tick)
  );

  // scale capture; zero behaves as one
  assign scaleIn = (delayScale == '0) ? COEF_W'(1) : delayScale;
  assign coefEff = strobe.latchCfg ? scaleIn : coefQ;

  always_ff @(posedge clk) begin
    if (!rstN)                coefQ <= COEF_W'(1);
    else if (strobe.latchCfg) coefQ <= scaleIn;
  end

  // phase timer
  assign loadVal = TIMER_W'(baseMicros(strobe.slotType, strobe.phase)) * TIMER_W'(coefEff);
  assign expire  = tick && (timerQ == TIMER_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)                          timerQ <= '0;
    else if (strobe.load)               timerQ <= loadVal;
    else if (tick && (timerQ != '0))    timerQ <= timerQ - 1'b1;
  end

  // line synchronizer, idle level high
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_DEPTH-2:0], lineIn};
  end
  assign lineSync = syncQ[SYNC_DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rstN)                sampleQ <= 1'b0;
    else if (strobe.latchCfg) sampleQ <= 1'b0;
    else if (strobe.capture)  sampleQ <= lineSync;
  end
  assign bitOut = sampleQ;

  // R7
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (timerQ != '0));

  // R11
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !strobe.latchCfg) |=> $stable(sampleQ));

endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  reqKind,
  input  logic        reqBit,
  input  logic        expire,
  output ctrlStrobe_t strobe,
  output logic        driveLow,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_GAP, ST_TAIL} state_e;

  state_e    stateQ, stateD;
  slotType_e slotQ;
  slotType_e reqType;
  logic      doneQ, doneD;

  assign reqType = decodeReq(reqKind_e'(reqKind), reqBit);

  always_comb begin
    stateD          = stateQ;
    doneD           = 1'b0;
    strobe          = '0;
    strobe.phase    = PH_LOW;
    strobe.slotType = slotQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.load     = 1'b1;
          strobe.latchCfg = 1'b1;
          strobe.slotType = reqType;
          strobe.phase    = PH_LOW;
          stateD          = ST_LOW;
        end
      end
      ST_LOW: begin
        if (expire) begin
          strobe.load  = 1'b1;
          strobe.phase = PH_GAP;
          stateD       = ST_GAP;
        end
      end
      ST_GAP: begin
        if (expire) begin
          strobe.load    = 1'b1;
          strobe.phase   = PH_TAIL;
          strobe.capture = (slotQ == SLOT_RD) || (slotQ == SLOT_RST);
          stateD         = ST_TAIL;
        end
      end
      default: begin
        if (expire) begin
          stateD = ST_IDLE;
          doneD  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
      slotQ  <= SLOT_WR1;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
      if (stateQ == ST_IDLE && start) slotQ <= reqType;
    end
  end

  assign busy     = (stateQ != ST_IDLE);
  assign driveLow = (stateQ == ST_LOW);
  assign done     = doneQ;

  // R10
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(slotQ));

  // R8
  low_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveLow) |-> $past(start));

endmodule

// File: rtl/ow_slot_gen.sv
module ow_slot_gen
  import ow_slot_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned COEF_W     = 4,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        reqKind,
  input  logic              reqBit,
  input  logic [COEF_W-1:0] delayScale,
  input  logic              lineIn,
  output logic              driveLow,
  output logic              busy,
  output logic              done,
  output logic              bitOut
);
  localparam int unsigned CLKS_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;

  ctrlStrobe_t strobe;
  logic        expire;

  ow_slot_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .reqKind  (reqKind),
    .reqBit   (reqBit),
    .expire   (expire),
    .strobe   (strobe),
    .driveLow (driveLow),
    .busy     (busy),
    .done     (done)
  );

  ow_slot_datapath #(
    .CLKS_PER_US (CLKS_PER_US),
    .COEF_W      (COEF_W),
    .SYNC_DEPTH  (SYNC_DEPTH)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .delayScale (delayScale),
    .lineIn     (lineIn),
    .expire     (expire),
    .bitOut     (bitOut)
  );

endmodule

// File: tb/test_ow_slot_gen.sv
module test_ow_slot_gen;
  localparam int CLK_HZ = 4_000_000;
  localparam int P      = 4;
  localparam int COEF_W = 4;
  localparam int WATCHDOG = 150_000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic reqBit = 1'b0;
  logic [COEF_W-1:0] delayScale = 4'd1;
  logic lineIn = 1'b1;
  logic driveLow, busy, done, bitOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string curTag = "R1";

  always #10 clk = ~clk;

  ow_slot_gen #(.CLK_HZ(CLK_HZ), .COEF_W(COEF_W)) i_ow_slot_gen (
    .clk(clk), .rstN(rstN), .start(start), .reqKind(reqKind), .reqBit(reqBit),
    .delayScale(delayScale), .lineIn(lineIn), .driveLow(driveLow), .busy(busy),
    .done(done), .bitOut(bitOut)
  );

  // ---------------- behavioural reference ----------------
  // slot types: 0 write-0, 1 write-1, 2 read, 3 reset
  function automatic int lowUs(int t);
    case (t) 0: return 60; 1: return 6; 2: return 6; default: return 500; endcase
  endfunction
  function automatic int relUs(int t);
    case (t) 0: return 10; 1: return 64; 2: return 64; default: return 500; endcase
  endfunction
  function automatic int sampUs(int t);
    case (t) 2: return 9; 3: return 70; default: return 0; endcase
  endfunction
  function automatic int typeOf(int kind, bit b);
    case (kind) 0: return 3; 1: return b ? 1 : 0; 2: return b ? 2 : 0; default: return 2; endcase
  endfunction

  int mBusy, mDone, mBit, mCnt, mLow, mRel, mSamp, mRead;
  bit mS1, mS2;

  always @(posedge clk) begin
    bit capVal;
    int t, k;
    capVal = mS2;
    mS2 = mS1;
    mS1 = lineIn;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mBit = 0; mCnt = 0; mS1 = 1; mS2 = 1;
      mLow = 0; mRel = 0; mSamp = 0; mRead = 0;
    end else begin
      mDone = 0;
      if (mBusy == 0) begin
        if (start) begin
          t = typeOf(int'(reqKind), reqBit);
          k = (delayScale == 0) ? 1 : int'(delayScale);
          mLow = lowUs(t) * k * P;
          mRel = relUs(t) * k * P;
          mSamp = sampUs(t) * k * P;
          mRead = (t >= 2);
          mCnt = 0; mBusy = 1; mBit = 0;
        end
      end else begin
        mCnt++;
        if (mRead != 0 && mCnt == mLow + mSamp) mBit = capVal;
        if (mCnt == mLow + mRel) begin
          mBusy = 0; mDone = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    bit eDrive;
    eDrive = (mBusy != 0) && (mCnt < mLow);
    checks++;
    if (driveLow !== eDrive || busy !== (mBusy != 0) || done !== (mDone != 0) || bitOut !== mBit[0]) begin
      failures++;
      $display("FAIL %s cycle %0d: drive/busy/done/bit = %b%b%b%b expected %b%b%b%b",
               curTag, cycles, driveLow, busy, done, bitOut,
               eDrive, mBusy != 0, mDone != 0, mBit[0]);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d (tag %s)", cycles, curTag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one slot: counts low and busy cycles, optional poke while busy
  task automatic runSlot(input string tag, input int kind, input bit b, input int scale,
                         input bit line, input int pokeAt, input int pokeKind, input int pokeScale,
                         input int expLowUs, input int expTotUs, input int expK, input int expBit);
    int low, tot;
    curTag = tag;
    @(negedge clk);
    lineIn = line; reqKind = 2'(kind); reqBit = b; delayScale = COEF_W'(scale); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    low = 0; tot = 0;
    while (!done && tot < 60000) begin
      low += int'(driveLow);
      tot += int'(busy);
      @(negedge clk);
      if (tot == pokeAt) begin
        start = 1'b1; reqKind = 2'(pokeKind); delayScale = COEF_W'(pokeScale);
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check({tag, " low cycles"}, low, expLowUs * expK * P);
    check({tag, " busy cycles"}, tot, expTotUs * expK * P);
    check({tag, " bitOut"}, int'(bitOut), expBit);
  endtask

  // read slot with the line falling n negedges after the accepting edge
  task automatic syncProbe(input string tag, input int n, input int expBit);
    curTag = tag;
    @(negedge clk);
    lineIn = 1'b1; reqKind = 2'd3; reqBit = 1'b0; delayScale = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (n) @(negedge clk);
    lineIn = 1'b0;
    while (!done) @(negedge clk);
    check({tag, " sync window bitOut"}, int'(bitOut), expBit);
    lineIn = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 driveLow", int'(driveLow), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 bitOut", int'(bitOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    runSlot("R2 R8 R11 write-1",     1, 1, 1, 1, -1, 0, 0, 6,   70,   1, 0);
    runSlot("R3 write-0",            1, 0, 1, 1, -1, 0, 0, 60,  70,   1, 0);
    runSlot("R4 read high",          3, 0, 1, 1, -1, 0, 0, 6,   70,   1, 1);
    runSlot("R4 read low",           3, 0, 1, 0, -1, 0, 0, 6,   70,   1, 0);
    runSlot("R5 reset presence",     0, 0, 1, 0, -1, 0, 0, 500, 1000, 1, 0);
    runSlot("R5 reset no device",    0, 0, 1, 1, -1, 0, 0, 500, 1000, 1, 1);
    runSlot("R6 touch one",          2, 1, 1, 1, -1, 0, 0, 6,   70,   1, 1);
    runSlot("R6 R11 touch zero",     2, 0, 1, 1, -1, 0, 0, 60,  70,   1, 0);
    runSlot("R7 scale three read",   3, 0, 3, 1, -1, 0, 0, 6,   70,   3, 1);
    runSlot("R7 scale zero as one",  1, 0, 0, 1, -1, 0, 0, 60,  70,   1, 0);
    runSlot("R7 scale two reset",    0, 0, 2, 0, -1, 0, 0, 500, 1000, 2, 0);
    runSlot("R10 R7 start ignored",  1, 1, 1, 1, 20, 0, 5, 6,   70,   1, 0);
    check("R10 idle after ignored start", int'(busy), 0);

    // R9: capture edge is 15*P edges after accept
    syncProbe("R9 late change", 15 * P - 2, 1);
    syncProbe("R9 early change", 15 * P - 3, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule